// File: doc/BRIEF.md
# Template-Directed Bundle Issue Stage

This block is the in-order issue stage for fixed-size instruction bundles. A bundle is 128 bits: three 41-bit instruction slots and a 5-bit template. The template says which execution-unit class each slot goes to and where the stop marks sit. A stop mark closes an independent instruction group. Because the template states the parallelism directly, the stage does no dependency checking. It only follows the stops. A group may start or end in the middle of a bundle.

The stage reads the two oldest entries of an upstream bundle queue. In one cycle it issues up to two bundles, at most six instructions, strictly in program order. It halts at the first stop mark it meets, so a later group never leaves in the same cycle as an earlier one. When a stop falls inside a bundle, an internal slot pointer records where to resume, and the remaining slots issue on a following cycle. Nop slots take no issue lane. A bundle whose template is reserved raises an error pulse, is discarded from the queue and issues nothing.

Each cycle the stage tells the queue combinationally how many bundles to pop. The instructions picked in that cycle appear on registered lane outputs after the next clock edge.

Top module: `bundle_issuer`

## Requirements
- R1: Bundle layout: template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46], slot 2 in [127:87]. Every issued lane carries the exact 41 bits of the slot it came from.
- R2: The unit code on each issued lane (0 memory, 1 integer, 2 floating point, 3 branch) comes from template bits [4:1] through this table:
  - 0 and 1: MEM INT INT
  - 2 and 3: MEM MEM INT
  - 4: MEM FP INT
  - 5: MEM MEM FP
  - 6: MEM INT BR
  - 7: MEM BR BR
  - 8: BR BR BR
  - 9: MEM MEM BR
  - 10: MEM FP BR
  - 11: MEM INT INT
- R3: Template bit 0 places a stop after slot 2. Combination 1 adds a stop after slot 1. Combinations 3 and 11 add a stop after slot 0. No slot after a stop issues in the same cycle as the slots before it.
- R4: popCount is at most 2, and it is 0 whenever head 0 is not valid. The second bundle is considered only when the first one is completely consumed with no stop after its last slot.
- R5: When a stop ends issue inside a bundle, that bundle stays at the head of the queue. The next cycle resumes at the slot just after the stop.
- R6: A reserved template (bits [4:1] of 12 to 15) at head 0 pops that bundle with no lane valid and drives issueErr high on the following cycle. A reserved bundle at head 1 ends the current cycle's issue in front of it.
- R7: A slot whose 41 bits are all zero is a nop and takes no lane. The remaining slots fill lanes from lane 0 upward in program order, with no gaps.
- R8: Lane outputs and issueErr are registered. They show the selection made in the previous cycle, and they are all zero after reset.
- R9: With no valid head, nothing is popped, and no lane or error is raised on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | 2 | Valid flags of the two oldest queue entries (bit 1 implies bit 0) |
| headBundles | input | 256 | The two oldest bundles; entry b sits at [b*128 +: 128] |
| popCount | output | 2 | Bundles to remove from the queue at this clock edge |
| issueValid | output | 6 | Per-lane issue valid |
| issueUnit | output | 12 | Per-lane unit code, lane k at [2k +: 2] |
| issueInstr | output | 246 | Per-lane instruction bits, lane k at [41k +: 41] |
| issueErr | output | 1 | Reserved-template bundle discarded in the previous cycle |

## Verification
popCount is combinational. The bench reads it one time unit after it drives the heads, in the same cycle. The lanes and issueErr belong to the selection made in the cycle before. The driver therefore pushes each cycle's expected lane set into a queue when it makes that cycle's pop decision. The monitor pops the entry at the next falling edge, which comes after exactly one register stage. The bench also vetoes the reset value and the result one cycle after an idle cycle.

// File: rtl/bissue_pkg.sv
package bissue_pkg;
  parameter int SLOT_W      = 41;
  parameter int TMPL_W      = 5;
  parameter int SLOTS       = 3;
  parameter int WIN_BUNDLES = 2;
  parameter int UNIT_W      = 2;

  localparam int BUNDLE_W = SLOTS * SLOT_W + TMPL_W;
  localparam int LANES    = SLOTS * WIN_BUNDLES;
  localparam int PTR_W    = $clog2(SLOTS);
  localparam int POP_W    = $clog2(WIN_BUNDLES + 1);
  localparam int COMBO_W  = TMPL_W - 1;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_MEM = 2'd0,
    UNIT_INT = 2'd1,
    UNIT_FP  = 2'd2,
    UNIT_BR  = 2'd3
  } unit_e;

  typedef struct packed {
    logic                          bad;
    logic [SLOTS-1:0][UNIT_W-1:0]  unit;
    logic [SLOTS-1:0]              stopAfter;
  } tmplInfo_t;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [LANES-1:0] take;
    logic             err;
  } ctlStrobe_t;

  function automatic tmplInfo_t decodeTmpl(input logic [TMPL_W-1:0] t);
    tmplInfo_t   d;
    unit_e       u0, u1, u2;
    logic [SLOTS-1:0] mid;
    logic        reserved;
    int          nFp, nMem;
    reserved = 1'b0;
    mid      = '0;
    u0 = UNIT_MEM; u1 = UNIT_INT; u2 = UNIT_INT;
    case (t[TMPL_W-1:1])
      COMBO_W'(0):  ;
      COMBO_W'(1):  mid = 3'b010;
      COMBO_W'(2):  u1 = UNIT_MEM;
      COMBO_W'(3):  begin u1 = UNIT_MEM; mid = 3'b001; end
      COMBO_W'(4):  u1 = UNIT_FP;
      COMBO_W'(5):  begin u1 = UNIT_MEM; u2 = UNIT_FP; end
      COMBO_W'(6):  u2 = UNIT_BR;
      COMBO_W'(7):  begin u1 = UNIT_BR; u2 = UNIT_BR; end
      COMBO_W'(8):  begin u0 = UNIT_BR; u1 = UNIT_BR; u2 = UNIT_BR; end
      COMBO_W'(9):  begin u1 = UNIT_MEM; u2 = UNIT_BR; end
      COMBO_W'(10): begin u1 = UNIT_FP; u2 = UNIT_BR; end
      COMBO_W'(11): mid = 3'b001;
      default:      reserved = 1'b1;
    endcase
    d.unit[0] = u0;
    d.unit[1] = u1;
    d.unit[2] = u2;
    d.stopAfter = mid | {t[0], 2'b00};
    nFp = 0; nMem = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (d.unit[s] == UNIT_FP)  nFp++;
      if (d.unit[s] == UNIT_MEM) nMem++;
    end
    d.bad = reserved || (nFp > 1) || (nMem > 2);
    return d;
  endfunction
endpackage

// File: rtl/bissue_ctrl.sv
module bissue_ctrl
  import bissue_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WIN_BUNDLES-1:0]        headValid,
  input  logic [WIN_BUNDLES*TMPL_W-1:0] tmpls,
  output logic [POP_W-1:0]              popCount,
  output ctlStrobe_t                    strobe
);
  tmplInfo_t        info [WIN_BUNDLES];
  logic [PTR_W-1:0] slotPtr, nextPtr;

  genvar gb;
  generate
    for (gb = 0; gb < WIN_BUNDLES; gb++) begin : g_dec
      assign info[gb] = decodeTmpl(tmpls[gb*TMPL_W +: TMPL_W]);
    end
  endgenerate

  always_comb begin
    logic cont;
    strobe   = '0;
    popCount = '0;
    nextPtr  = slotPtr;
    cont     = 1'b1;
    for (int b = 0; b < WIN_BUNDLES; b++) begin
      if (cont) begin
        if (!headValid[b]) begin
          cont = 1'b0;
        end else if (info[b].bad) begin
          if (b == 0) begin
            strobe.err = 1'b1;
            popCount   = POP_W'(1);
            nextPtr    = '0;
          end
          cont = 1'b0;
        end else begin
          for (int s = 0; s < SLOTS; s++) begin
            if (cont && (b > 0 || s >= int'(slotPtr))) begin
              strobe.take[b*SLOTS + s] = 1'b1;
              if (s == SLOTS - 1) begin
                popCount = POP_W'(b + 1);
                nextPtr  = '0;
              end
              if (info[b].stopAfter[s]) begin
                cont = 1'b0;
                if (s < SLOTS - 1) nextPtr = PTR_W'(s + 1);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotPtr <= '0;
    else       slotPtr <= nextPtr;
  end
endmodule

// File: rtl/bissue_datapath.sv
module bissue_datapath
  import bissue_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [WIN_BUNDLES*BUNDLE_W-1:0] headBundles,
  input  ctlStrobe_t                      strobe,
  output logic [LANES-1:0]                issueValid,
  output logic [LANES*UNIT_W-1:0]         issueUnit,
  output logic [LANES*SLOT_W-1:0]         issueInstr,
  output logic                            issueErr
);
  logic [SLOT_W-1:0] winInstr [LANES];
  logic [UNIT_W-1:0] winUnit  [LANES];

  genvar gw;
  generate
    for (gw = 0; gw < LANES; gw++) begin : g_win
      localparam int B = gw / SLOTS;
      localparam int S = gw % SLOTS;
      tmplInfo_t wInfo;
      assign wInfo        = decodeTmpl(headBundles[B*BUNDLE_W +: TMPL_W]);
      assign winInstr[gw] = headBundles[B*BUNDLE_W + TMPL_W + S*SLOT_W +: SLOT_W];
      assign winUnit[gw]  = wInfo.unit[S];
    end
  endgenerate

  logic [LANES-1:0]        nxtValid;
  logic [LANES*UNIT_W-1:0] nxtUnit;
  logic [LANES*SLOT_W-1:0] nxtInstr;

  always_comb begin
    int lane;
    nxtValid = '0;
    nxtUnit  = '0;
    nxtInstr = '0;
    lane     = 0;
    for (int w = 0; w < LANES; w++) begin
      if (strobe.take[w] && (winInstr[w] != '0)) begin
        nxtValid[lane]                   = 1'b1;
        nxtUnit[lane*UNIT_W +: UNIT_W]   = winUnit[w];
        nxtInstr[lane*SLOT_W +: SLOT_W]  = winInstr[w];
        lane++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid <= '0;
      issueUnit  <= '0;
      issueInstr <= '0;
      issueErr   <= 1'b0;
    end else begin
      issueValid <= nxtValid;
      issueUnit  <= nxtUnit;
      issueInstr <= nxtInstr;
      issueErr   <= strobe.err;
    end
  end
endmodule

// File: rtl/bundle_issuer.sv
module bundle_issuer
  import bissue_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [WIN_BUNDLES-1:0]          headValid,
  input  logic [WIN_BUNDLES*BUNDLE_W-1:0] headBundles,
  output logic [POP_W-1:0]                popCount,
  output logic [LANES-1:0]                issueValid,
  output logic [LANES*UNIT_W-1:0]         issueUnit,
  output logic [LANES*SLOT_W-1:0]         issueInstr,
  output logic                            issueErr
);
  ctlStrobe_t                    strobe;
  logic [WIN_BUNDLES*TMPL_W-1:0] tmpls;

  genvar gb;
  generate
    for (gb = 0; gb < WIN_BUNDLES; gb++) begin : g_tmpl
      assign tmpls[gb*TMPL_W +: TMPL_W] = headBundles[gb*BUNDLE_W +: TMPL_W];
    end
  endgenerate

  bissue_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .tmpls(tmpls),
    .popCount(popCount), .strobe(strobe)
  );

  bissue_datapath u_dp (
    .clk(clk), .rstN(rstN), .headBundles(headBundles), .strobe(strobe),
    .issueValid(issueValid), .issueUnit(issueUnit),
    .issueInstr(issueInstr), .issueErr(issueErr)
  );
endmodule

// File: rtl/bissue_checker.sv
module bissue_checker
  import bissue_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [WIN_BUNDLES-1:0] headValid,
  input logic [POP_W-1:0]       popCount,
  input logic [LANES-1:0]       issueValid,
  input logic                   issueErr
);
  p_pop_max_r4: assert property (@(posedge clk) disable iff (!rstN)
    popCount <= POP_W'(WIN_BUNDLES));

  p_second_needs_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    (popCount == POP_W'(2)) |-> headValid[1]);

  p_no_pop_when_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    !headValid[0] |-> (popCount == '0));

  p_idle_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    !headValid[0] |=> (issueValid == '0 && !issueErr));

  p_err_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueErr |-> (issueValid == '0));

  p_lanes_packed_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((issueValid + LANES'(1)) & issueValid) == '0);
endmodule

bind bundle_issuer bissue_checker chk (
  .clk(clk), .rstN(rstN), .headValid(headValid), .popCount(popCount),
  .issueValid(issueValid), .issueErr(issueErr)
);

// File: tb/tb_bundle_issuer.sv
module tb_bundle_issuer;
  import bissue_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [LANES-1:0]        v;
    logic [LANES*UNIT_W-1:0] u;
    logic [LANES*SLOT_W-1:0] ins;
    logic                    err;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIN_BUNDLES-1:0]          headValid = '0;
  logic [WIN_BUNDLES*BUNDLE_W-1:0] headBundles = '0;
  logic [POP_W-1:0]                popCount;
  logic [LANES-1:0]                issueValid;
  logic [LANES*UNIT_W-1:0]         issueUnit;
  logic [LANES*SLOT_W-1:0]         issueInstr;
  logic                            issueErr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [BUNDLE_W-1:0] bq[$];
  expItem_t expQ[$];
  int mPtr = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_issuer dut (.*);

  // Table from R2/R3: units {slot2,slot1,slot0}, extra stop bits.
  function automatic logic [5:0] tbUnits(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd11: return {2'd1, 2'd1, 2'd0};
      4'd2, 4'd3:        return {2'd1, 2'd0, 2'd0};
      4'd4:  return {2'd1, 2'd2, 2'd0};
      4'd5:  return {2'd2, 2'd0, 2'd0};
      4'd6:  return {2'd3, 2'd1, 2'd0};
      4'd7:  return {2'd3, 2'd3, 2'd0};
      4'd8:  return {2'd3, 2'd3, 2'd3};
      4'd9:  return {2'd3, 2'd0, 2'd0};
      4'd10: return {2'd3, 2'd2, 2'd0};
      default: return 6'd0;
    endcase
  endfunction

  function automatic bit tbStop(input logic [4:0] t, input int s);
    if (s == 2) return t[0];
    if (s == 1) return t[4:1] == 4'd1;
    return (t[4:1] == 4'd3) || (t[4:1] == 4'd11);
  endfunction

  function automatic bit tbBad(input logic [BUNDLE_W-1:0] b);
    return b[4:1] >= 4'd12;
  endfunction

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [BUNDLE_W-1:0] mkBundle(input logic [4:0] t, input logic [40:0] a,
                                                   input logic [40:0] b, input logic [40:0] c);
    return {c, b, a, t};
  endfunction

  // Driver: one cycle of stimulus plus the model's expectation.
  task automatic stepCycle(input int lim);
    expItem_t e;
    int nvis, lane, pop, np;
    @(negedge clk);
    nvis = (bq.size() < lim) ? bq.size() : lim;
    headValid   = '0;
    headBundles = '0;
    for (int b = 0; b < nvis; b++) begin
      headValid[b] = 1'b1;
      headBundles[b*BUNDLE_W +: BUNDLE_W] = bq[b];
    end
    #1;
    e = '0; lane = 0; pop = 0; np = mPtr;
    if (nvis > 0) begin
      if (tbBad(bq[0])) begin
        e.err = 1'b1; pop = 1; np = 0;
      end else begin
        for (int g = mPtr; g < 3*nvis; g++) begin
          int b, s;
          logic [40:0] ins;
          logic [5:0] us;
          b = g / 3; s = g % 3;
          if (s == 0 && b > 0 && tbBad(bq[b])) break;
          ins = bq[b][5 + 41*s +: 41];
          us  = tbUnits(bq[b][4:1]);
          if (ins != '0) begin
            e.v[lane] = 1'b1;
            e.u[2*lane +: 2] = us[2*s +: 2];
            e.ins[41*lane +: 41] = ins;
            lane++;
          end
          if (s == 2) begin pop = b + 1; np = 0; end
          if (tbStop(bq[b][4:0], s)) begin
            if (s < 2) np = s + 1;
            break;
          end
        end
      end
    end
    check(popCount == POP_W'(pop), "R4 R5 popCount", 256'(popCount), 256'(pop));
    expQ.push_back(e);
    for (int k = 0; k < pop; k++) void'(bq.pop_front());
    mPtr = np;
  endtask

  // Monitor: outputs are due one register stage after the decision (R8).
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(issueErr == e.err, "R6 issueErr", 256'(issueErr), 256'(e.err));
      check(issueValid == e.v, "R3 R5 R7 lane mask", 256'(issueValid), 256'(e.v));
      for (int k = 0; k < LANES; k++) begin
        if (e.v[k]) begin
          check(issueUnit[2*k +: 2] == e.u[2*k +: 2], "R2 lane unit",
                256'(issueUnit[2*k +: 2]), 256'(e.u[2*k +: 2]));
          check(issueInstr[41*k +: 41] == e.ins[41*k +: 41], "R1 lane instr",
                256'(issueInstr[41*k +: 41]), 256'(e.ins[41*k +: 41]));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R8: reset state
    check(issueValid == '0 && !issueErr, "R8 reset outputs", 256'(issueValid), 256'(0));
    // R9: idle cycle
    stepCycle(2);
    // Directed: combo 1 with end stop, mid stop after slot 1 (R3, R5)
    bq.push_back(mkBundle(5'b00011, 41'h11, 41'h12, 41'h13));
    // combo 3, no end stop, stop after slot 0, nop in slot 2 (R7)
    bq.push_back(mkBundle(5'b00110, 41'h21, 41'h22, 41'h0));
    // combo 8, chained with next (R4)
    bq.push_back(mkBundle(5'b10000, 41'h31, 41'h0, 41'h33));
    bq.push_back(mkBundle(5'b01001, 41'h41, 41'h42, 41'h43));
    // reserved template (R6)
    bq.push_back(mkBundle(5'b11000, 41'h51, 41'h52, 41'h53));
    // reserved behind a continuing bundle (R6)
    bq.push_back(mkBundle(5'b10100, 41'h61, 41'h62, 41'h63));
    bq.push_back(mkBundle(5'b11110, 41'h71, 41'h72, 41'h73));
    // all-nop bundle (R7)
    bq.push_back(mkBundle(5'b00000, 41'h0, 41'h0, 41'h0));
    bq.push_back(mkBundle(5'b01101, 41'h81, 41'h82, 41'h83));
    while (bq.size() > 0) stepCycle(2);
    stepCycle(2);
    // Pseudo-random phase with a varying number of visible heads
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [40:0] sl [3];
      logic [3:0] combo;
      r = nextRand();
      combo = 4'(r[3:0] % 14);
      for (int s = 0; s < 3; s++) begin
        logic [31:0] q;
        q = nextRand();
        sl[s] = (q[1:0] == 2'b00) ? 41'h0 : {q[8:0], nextRand()} | 41'h1;
      end
      bq.push_back(mkBundle({combo, r[4]}, sl[0], sl[1], sl[2]));
      if (bq.size() > 3) begin
        logic [31:0] q;
        q = nextRand();
        stepCycle((q[2:0] == 3'd0) ? 0 : (q[2:0] == 3'd1) ? 1 : 2);
      end
    end
    while (bq.size() > 0) stepCycle(2);
    stepCycle(2);
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule